// File: doc/BRIEF.md
# Reduced-Register Illegal-Instruction Detector

This block sits between the instruction decoder and the trap logic of a small RISC-V core built for the embedded base variant, where only the sixteen general-purpose registers x0..x15 exist. For every instruction the core accepts, it looks at the 32-bit form of the instruction after any compressed expansion. From the major opcode and funct3 it works out which of the rd, rs1 and rs2 fields really name registers. It raises a combinational `illegal` flag when one of those fields addresses x16..x31. It also raises the flag when the compressed expander could not translate a 16-bit word.

A two-state machine remembers whether the most recently accepted instruction was illegal, and also keeps the word that caused it. When the core takes a trap, the block loads the cause code and the trap value that the core writes into its trap CSRs. An interrupt taken in the same trap wins over everything else. A remembered illegal instruction gives cause 2 and the faulting word as trap value. Any other trap passes through the cause and value supplied by the core. In the core's register file the four machine CSRs follow the sixteen GPRs at indices 16..19, in this order: scratch, trap vector, exception PC, trap value. The trap value computed here is the word written to index 19.

States: `ST_CLEAN` (no fault pending) and `ST_FAULT` (the last accepted instruction was illegal). Transitions: `ST_CLEAN -> ST_FAULT` when an illegal instruction is accepted and no trap is taken in that cycle. `ST_FAULT -> ST_CLEAN` when a trap is taken or a legal instruction is accepted. `ST_FAULT -> ST_FAULT` when another illegal instruction is accepted; this reloads the stored word.

Top module: `rvedet_top`

## Requirements
- R1: With `REDUCED`=1 and `ack` high, `illegal` is high in the same cycle when any register field used by the instruction holds a value of 16 or more. Fields: rd=[11:7], rs1=[19:15], rs2=[24:20]. A value of 15 is legal.
- R2: The fields checked depend on the opcode in bits [6:0]. 0110011 checks rd, rs1 and rs2. 0010011, 0000011 and 1100111 check rd and rs1. 0100011 and 1100011 check rs1 and rs2. 0110111, 0010111 and 1101111 check rd only. 0001111 and all other opcodes check no field.
- R3: For opcode 1110011, funct3=[14:12] selects the fields. funct3=0 checks no field. funct3 with bit 2 set (a CSR operation with an immediate) checks rd only, never the immediate in rs1. Any other funct3 checks rd and rs1.
- R4: When `expand_fail` is high, `illegal` is high only if `instr_raw[1:0]` is not 2'b11.
- R5: While `ack` is low, `illegal` is low, and the instruction presented is not remembered as a fault.
- R6: On a trap (`trap_take`) without `irq_take` after an illegal instruction was accepted, the next cycle shows `trap_code`=2, `trap_irq`=0 and a `trap_val` equal to the fetched word. For a 16-bit word (`instr_raw[1:0]` not 2'b11) the value is `{16'h0, instr_raw[15:0]}`.
- R7: On a trap with `irq_take` high, the next cycle shows `trap_irq`=1, `trap_code`=`IRQ_CODE` (default 11) and `trap_val`=0, whatever fault is pending.
- R8: On a trap with no interrupt and no pending fault, the next cycle shows `trap_code`=`exc_code` and `trap_val`=`other_tval`. Without `trap_take`, all trap outputs hold their values.
- R9: With `REDUCED`=0, register numbers never set `illegal`. The compressed-failure rule of R4 still applies.
- R10: During reset and after it, `trap_irq`, `trap_code` and `trap_val` are zero and no fault is pending.
- R11: A legal instruction accepted after an illegal one clears the pending fault, so a later trap reports `exc_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack | input | 1 | Instruction accepted this cycle |
| instr_exp | input | 32 | Instruction after compressed expansion |
| instr_raw | input | 32 | Word as fetched |
| expand_fail | input | 1 | Expander found no valid translation |
| trap_take | input | 1 | Core takes a trap this cycle |
| irq_take | input | 1 | The trap taken is an interrupt |
| exc_code | input | 4 | Cause code for non-illegal exceptions |
| other_tval | input | 32 | Trap value for non-illegal exceptions |
| illegal | output | 1 | Instruction is illegal (combinational) |
| trap_irq | output | 1 | Registered interrupt flag of the cause |
| trap_code | output | 4 | Registered exception/interrupt code |
| trap_val | output | 32 | Registered trap value |

## Verification
The `illegal` flag depends only on the current inputs, so the bench changes inputs on a falling edge and reads the flag 1 ns later, within the same cycle. The trap outputs change on the rising edge that samples `trap_take`. The bench therefore raises `trap_take` on one falling edge and reads the trap outputs on the next falling edge, one register stage later. The FSM moves on the rising edge after `ack`, so each trap sequence places the accepted instruction at least one cycle before `trap_take`.

// File: rtl/rvedet_pkg.sv
package rvedet_pkg;

    typedef enum logic [0:0] {
        ST_CLEAN = 1'b0,
        ST_FAULT = 1'b1
    } det_state_e;

    typedef struct packed {
        logic rd;
        logic rs1;
        logic rs2;
    } field_use_t;

    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_FENCE  = 7'b0001111;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    localparam int CAUSE_ILLEGAL = 2;

endpackage

// File: rtl/rvedet_fields.sv
module rvedet_fields
    import rvedet_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    output field_use_t use_o
);

    always_comb begin
        use_o = '0;
        unique case (opcode)
            OPC_OP: begin
                use_o.rd  = 1'b1;
                use_o.rs1 = 1'b1;
                use_o.rs2 = 1'b1;
            end
            OPC_OPIMM, OPC_LOAD, OPC_JALR: begin
                use_o.rd  = 1'b1;
                use_o.rs1 = 1'b1;
            end
            OPC_STORE, OPC_BRANCH: begin
                use_o.rs1 = 1'b1;
                use_o.rs2 = 1'b1;
            end
            OPC_LUI, OPC_AUIPC, OPC_JAL: begin
                use_o.rd = 1'b1;
            end
            OPC_SYSTEM: begin
                if (funct3 == 3'b000) begin
                    use_o = '0;
                end else if (funct3[2]) begin
                    use_o.rd = 1'b1;
                end else begin
                    use_o.rd  = 1'b1;
                    use_o.rs1 = 1'b1;
                end
            end
            default: use_o = '0;
        endcase
    end

endmodule

// File: rtl/rvedet_range.sv
module rvedet_range
    import rvedet_pkg::*;
#(
    parameter int REDUCED = 1,
    parameter int NUM_GPR = 16,
    parameter int IDX_W   = 5
) (
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic [IDX_W-1:0] rs2_idx,
    input  field_use_t       use_i,
    output logic             bad
);

    localparam int NFIELD = 3;
    localparam logic [IDX_W:0] LIMIT = NUM_GPR[IDX_W:0];

    generate
        if (REDUCED != 0) begin : g_reduced
            logic [NFIELD-1:0][IDX_W-1:0] idx;
            logic [NFIELD-1:0]            used;
            logic [NFIELD-1:0]            hit;

            assign idx  = {rs2_idx, rs1_idx, rd_idx};
            assign used = {use_i.rs2, use_i.rs1, use_i.rd};

            for (genvar g = 0; g < NFIELD; g++) begin : g_field
                assign hit[g] = used[g] && ({1'b0, idx[g]} >= LIMIT);
            end

            assign bad = |hit;
        end else begin : g_full
            logic unused_fields;
            assign unused_fields = ^{rd_idx, rs1_idx, rs2_idx, use_i};
            assign bad = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/rvedet_trap.sv
module rvedet_trap
    import rvedet_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CODE_W   = 4,
    parameter int IRQ_CODE = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack,
    input  logic              illegal,
    input  logic [XLEN-1:0]   fault_word,
    input  logic              trap_take,
    input  logic              irq_take,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   other_tval,
    output logic              trap_irq,
    output logic [CODE_W-1:0] trap_code,
    output logic [XLEN-1:0]   trap_val
);

    localparam logic [CODE_W-1:0] CODE_IRQ = IRQ_CODE[CODE_W-1:0];
    localparam logic [CODE_W-1:0] CODE_ILL = CAUSE_ILLEGAL[CODE_W-1:0];

    det_state_e      state_q, state_d;
    logic [XLEN-1:0] word_q;
    logic            capture;

    assign capture = ack && illegal && !trap_take;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: if (capture) state_d = ST_FAULT;
            ST_FAULT: if (trap_take || (ack && !illegal)) state_d = ST_CLEAN;
            default:  state_d = ST_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= fault_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_irq  <= 1'b0;
            trap_code <= '0;
            trap_val  <= '0;
        end else if (trap_take) begin
            if (irq_take) begin
                trap_irq  <= 1'b1;
                trap_code <= CODE_IRQ;
                trap_val  <= '0;
            end else if (state_q == ST_FAULT) begin
                trap_irq  <= 1'b0;
                trap_code <= CODE_ILL;
                trap_val  <= word_q;
            end else begin
                trap_irq  <= 1'b0;
                trap_code <= exc_code;
                trap_val  <= other_tval;
            end
        end
    end

endmodule

// File: rtl/rvedet_top.sv
module rvedet_top
    import rvedet_pkg::*;
#(
    parameter int REDUCED  = 1,
    parameter int NUM_GPR  = 16,
    parameter int IRQ_CODE = 11,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack,
    input  logic [31:0]       instr_exp,
    input  logic [31:0]       instr_raw,
    input  logic              expand_fail,
    input  logic              trap_take,
    input  logic              irq_take,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [31:0]       other_tval,
    output logic              illegal,
    output logic              trap_irq,
    output logic [CODE_W-1:0] trap_code,
    output logic [31:0]       trap_val
);

    localparam int XLEN  = 32;
    localparam int IDX_W = 5;
    localparam int HALF  = XLEN / 2;

    field_use_t      use_w;
    logic            range_bad;
    logic            comp_bad;
    logic            is_short;
    logic [XLEN-1:0] fault_word;
    logic            unused_funct7;

    assign unused_funct7 = ^instr_exp[31:25];

    rvedet_fields u_fields (
        .opcode (instr_exp[6:0]),
        .funct3 (instr_exp[14:12]),
        .use_o  (use_w)
    );

    rvedet_range #(
        .REDUCED (REDUCED),
        .NUM_GPR (NUM_GPR),
        .IDX_W   (IDX_W)
    ) u_range (
        .rd_idx  (instr_exp[11:7]),
        .rs1_idx (instr_exp[19:15]),
        .rs2_idx (instr_exp[24:20]),
        .use_i   (use_w),
        .bad     (range_bad)
    );

    assign is_short   = (instr_raw[1:0] != 2'b11);
    assign comp_bad   = expand_fail && is_short;
    assign illegal    = ack && (range_bad || comp_bad);
    assign fault_word = is_short ? {{HALF{1'b0}}, instr_raw[HALF-1:0]} : instr_raw;

    rvedet_trap #(
        .XLEN     (XLEN),
        .CODE_W   (CODE_W),
        .IRQ_CODE (IRQ_CODE)
    ) u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack        (ack),
        .illegal    (illegal),
        .fault_word (fault_word),
        .trap_take  (trap_take),
        .irq_take   (irq_take),
        .exc_code   (exc_code),
        .other_tval (other_tval),
        .trap_irq   (trap_irq),
        .trap_code  (trap_code),
        .trap_val   (trap_val)
    );

endmodule

// File: rtl/rvedet_chk.sv
module rvedet_chk
    import rvedet_pkg::*;
#(
    parameter int REDUCED  = 1,
    parameter int IRQ_CODE = 11,
    parameter int CODE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [31:0]       instr_exp,
    input logic [31:0]       instr_raw,
    input logic              expand_fail,
    input logic              trap_take,
    input logic              irq_take,
    input logic [CODE_W-1:0] exc_code,
    input logic [31:0]       other_tval,
    input logic              illegal,
    input logic              trap_irq,
    input logic [CODE_W-1:0] trap_code,
    input logic [31:0]       trap_val
);

    logic pend;

    always_ff @(posedge clk) begin
        if (!rst_n)                    pend <= 1'b0;
        else if (trap_take)            pend <= 1'b0;
        else if (ack && illegal)       pend <= 1'b1;
        else if (ack)                  pend <= 1'b0;
    end

    // R1
    lui_rd_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (REDUCED != 0 && ack && instr_exp[6:0] == OPC_LUI && instr_exp[11]) |-> illegal);

    // R4
    bad_expand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && expand_fail && instr_raw[1:0] != 2'b11) |-> illegal);

    // R5
    no_ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> !illegal);

    // R6
    illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && !irq_take && pend) |=> (trap_code == CAUSE_ILLEGAL[CODE_W-1:0] && !trap_irq));

    // R7
    irq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && irq_take) |=> (trap_irq && trap_code == IRQ_CODE[CODE_W-1:0] && trap_val == 32'h0));

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && !irq_take && !pend) |=> (trap_code == $past(exc_code) && trap_val == $past(other_tval)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_take |=> ($stable(trap_code) && $stable(trap_val) && $stable(trap_irq)));

endmodule

bind rvedet_top rvedet_chk #(
    .REDUCED  (REDUCED),
    .IRQ_CODE (IRQ_CODE),
    .CODE_W   (CODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .instr_exp   (instr_exp),
    .instr_raw   (instr_raw),
    .expand_fail (expand_fail),
    .trap_take   (trap_take),
    .irq_take    (irq_take),
    .exc_code    (exc_code),
    .other_tval  (other_tval),
    .illegal     (illegal),
    .trap_irq    (trap_irq),
    .trap_code   (trap_code),
    .trap_val    (trap_val)
);

// File: tb/rvedet_top_tb.sv
module rvedet_top_tb;

    localparam logic [6:0] O_LOAD = 7'b0000011, O_FENCE = 7'b0001111, O_OPIMM = 7'b0010011;
    localparam logic [6:0] O_STORE = 7'b0100011, O_OP = 7'b0110011, O_LUI = 7'b0110111;
    localparam logic [6:0] O_BR = 7'b1100011, O_JAL = 7'b1101111, O_SYS = 7'b1110011;

    function automatic logic [31:0] enc(logic [6:0] opc, logic [2:0] f3,
                                        logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
        return {7'b0, rs2, rs1, f3, rd, opc};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [15:0] raw16;
        logic        fail;
        logic        exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    // Tags: R1 range, R2 format, R3 system, R4 expander failure
    localparam vec_t VECS [NVEC] = '{
        '{enc(O_OP,    3'd0,  5,  6,  7), 16'h0, 1'b0, 1'b0, 8'd1},
        '{enc(O_OP,    3'd0, 16,  6,  7), 16'h0, 1'b0, 1'b1, 8'd1},
        '{enc(O_OP,    3'd0,  5,  6, 31), 16'h0, 1'b0, 1'b1, 8'd1},
        '{enc(O_OPIMM, 3'd0,  1,  2, 20), 16'h0, 1'b0, 1'b0, 8'd2},
        '{enc(O_OPIMM, 3'd0,  1, 17,  0), 16'h0, 1'b0, 1'b1, 8'd2},
        '{enc(O_STORE, 3'd2, 18,  1,  2), 16'h0, 1'b0, 1'b0, 8'd2},
        '{enc(O_BR,    3'd0,  0,  1, 16), 16'h0, 1'b0, 1'b1, 8'd2},
        '{enc(O_LUI,   3'd0,  3, 31, 31), 16'h0, 1'b0, 1'b0, 8'd2},
        '{enc(O_JAL,   3'd0, 20,  0,  0), 16'h0, 1'b0, 1'b1, 8'd2},
        '{enc(O_SYS,   3'd5,  1, 25,  0), 16'h0, 1'b0, 1'b0, 8'd3},
        '{enc(O_SYS,   3'd1,  1, 25,  0), 16'h0, 1'b0, 1'b1, 8'd3},
        '{enc(O_SYS,   3'd0,  0,  0, 18), 16'h0, 1'b0, 1'b0, 8'd3},
        '{enc(O_OPIMM, 3'd0,  1,  1,  0), 16'h4001, 1'b1, 1'b1, 8'd4},
        '{enc(O_OPIMM, 3'd0,  1,  1,  0), 16'h4003, 1'b1, 1'b0, 8'd4},
        '{enc(O_FENCE, 3'd0, 16, 17,  0), 16'h0, 1'b0, 1'b0, 8'd2},
        '{enc(O_LOAD,  3'd2, 15, 15,  0), 16'h0, 1'b0, 1'b0, 8'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ack = 1'b0;
    logic [31:0] instr_exp = '0;
    logic [31:0] instr_raw = '0;
    logic        expand_fail = 1'b0;
    logic        trap_take = 1'b0;
    logic        irq_take = 1'b0;
    logic [3:0]  exc_code = '0;
    logic [31:0] other_tval = '0;
    logic        illegal, trap_irq, illegal_f, trap_irq_f;
    logic [3:0]  trap_code, trap_code_f;
    logic [31:0] trap_val, trap_val_f;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rvedet_top #(.REDUCED(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .ack(ack), .instr_exp(instr_exp), .instr_raw(instr_raw),
        .expand_fail(expand_fail), .trap_take(trap_take), .irq_take(irq_take),
        .exc_code(exc_code), .other_tval(other_tval), .illegal(illegal),
        .trap_irq(trap_irq), .trap_code(trap_code), .trap_val(trap_val));

    rvedet_top #(.REDUCED(0)) u_full (
        .clk(clk), .rst_n(rst_n), .ack(ack), .instr_exp(instr_exp), .instr_raw(instr_raw),
        .expand_fail(expand_fail), .trap_take(trap_take), .irq_take(irq_take),
        .exc_code(exc_code), .other_tval(other_tval), .illegal(illegal_f),
        .trap_irq(trap_irq_f), .trap_code(trap_code_f), .trap_val(trap_val_f));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic accept(input logic [31:0] ins, input logic [31:0] raw, input logic fl);
        @(negedge clk);
        ack = 1'b1; instr_exp = ins; instr_raw = raw; expand_fail = fl;
        trap_take = 1'b0; irq_take = 1'b0;
    endtask

    task automatic trap(input logic irq, input logic [3:0] code, input logic [31:0] tv);
        @(negedge clk);
        ack = 1'b0; expand_fail = 1'b0;
        trap_take = 1'b1; irq_take = irq; exc_code = code; other_tval = tv;
        @(negedge clk);
        trap_take = 1'b0; irq_take = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 code", {28'b0, trap_code}, 32'd0);
        chk("R10 val", trap_val, 32'd0);
        chk("R10 irq", {31'b0, trap_irq}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 code after release", {28'b0, trap_code}, 32'd0);

        // Vector table (R1, R2, R3, R4)
        for (int i = 0; i < NVEC; i++) begin
            accept(VECS[i].ins, VECS[i].fail ? {16'h0, VECS[i].raw16} : VECS[i].ins, VECS[i].fail);
            #1;
            chk($sformatf("R%0d vector %0d illegal", VECS[i].req, i), {31'b0, illegal}, {31'b0, VECS[i].exp});
        end
        trap(1'b0, 4'd1, 32'h0);

        // R5: ack low masks a bad instruction and does not store it
        @(negedge clk);
        ack = 1'b0; instr_exp = enc(O_OP, 3'd0, 31, 31, 31); instr_raw = instr_exp;
        #1;
        chk("R5 no ack", {31'b0, illegal}, 32'd0);
        trap(1'b0, 4'd6, 32'h0000_0066);
        chk("R5 not remembered", {28'b0, trap_code}, 32'd6);

        // R6: 32-bit illegal register
        accept(enc(O_OP, 3'd0, 16, 1, 2), enc(O_OP, 3'd0, 16, 1, 2), 1'b0);
        trap(1'b0, 4'd5, 32'hDEAD_0000);
        chk("R6 code", {28'b0, trap_code}, 32'd2);
        chk("R6 val", trap_val, enc(O_OP, 3'd0, 16, 1, 2));
        chk("R6 irq", {31'b0, trap_irq}, 32'd0);

        // R6: untranslatable compressed word, upper half cleared
        accept(enc(O_OPIMM, 3'd0, 1, 1, 0), 32'hFFFF_4081, 1'b1);
        trap(1'b0, 4'd5, 32'hDEAD_0000);
        chk("R6 short code", {28'b0, trap_code}, 32'd2);
        chk("R6 short val", trap_val, 32'h0000_4081);

        // R7: interrupt overrides pending illegal
        accept(enc(O_LUI, 3'd0, 31, 0, 0), enc(O_LUI, 3'd0, 31, 0, 0), 1'b0);
        trap(1'b1, 4'd5, 32'hDEAD_0000);
        chk("R7 irq", {31'b0, trap_irq}, 32'd1);
        chk("R7 code", {28'b0, trap_code}, 32'd11);
        chk("R7 val", trap_val, 32'd0);

        // R8: other exception passes through, then holds
        trap(1'b0, 4'd5, 32'h0000_1234);
        chk("R8 code", {28'b0, trap_code}, 32'd5);
        chk("R8 val", trap_val, 32'h0000_1234);
        repeat (3) @(negedge clk);
        chk("R8 hold code", {28'b0, trap_code}, 32'd5);
        chk("R8 hold val", trap_val, 32'h0000_1234);

        // R11: legal instruction clears pending fault
        accept(enc(O_OP, 3'd0, 20, 1, 2), enc(O_OP, 3'd0, 20, 1, 2), 1'b0);
        accept(enc(O_OP, 3'd0, 3, 1, 2), enc(O_OP, 3'd0, 3, 1, 2), 1'b0);
        trap(1'b0, 4'd7, 32'h0000_AAAA);
        chk("R11 code", {28'b0, trap_code}, 32'd7);
        chk("R11 val", trap_val, 32'h0000_AAAA);

        // R9: full mode ignores register numbers, keeps expander rule
        accept(enc(O_OP, 3'd0, 31, 30, 29), enc(O_OP, 3'd0, 31, 30, 29), 1'b0);
        #1;
        chk("R9 full range", {31'b0, illegal_f}, 32'd0);
        accept(enc(O_OPIMM, 3'd0, 1, 1, 0), 32'h0000_0001, 1'b1);
        #1;
        chk("R9 full expand", {31'b0, illegal_f}, 32'd1);
        @(negedge clk);
        ack = 1'b0; expand_fail = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule